// File: doc/BRIEF.md
# Amplitude-Compensation Request Timer

This block paces the amplitude-compensation requests sent to an oscillator control system. It runs from a 32 kHz low-frequency clock and holds one software-writable byte that encodes a repeat interval in a compact floating-point form. The byte has a 5-bit mantissa and a 3-bit exponent. The interval is (mantissa * 16 + 15) * 2^exponent clock cycles, which covers values from 30 up to 65408 with eight bits. The counter reloads on every expiry, so requests repeat for as long as the block is enabled.

What happens at an expiry depends on the system power mode. In active mode, the block raises a one-cycle request pulse. In power-down mode, the expiry only sets an internal pending flag. The deferred request is released by the next recharge strobe, and only by that strobe. Expiries count only while the high-frequency crystal runs in its low-power mode, which a qualifier input reports. A configuration byte of zero switches the whole function off.

Top module: `amp_comp_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and `comp_req` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata[7:0]`: bits 7:3 hold the mantissa and bits 2:0 hold the exponent. From the next cycle, `cfg_rdata` returns the stored byte in bits 7:0, and bits 31:8 read as zero whatever was written to them.
- R3: While the stored byte is zero, no request is produced. Storing zero also drops a pending deferred request, so a later recharge strobe emits nothing.
- R4: In active mode (`pwr_down` = 0), with the qualifier high throughout, a nonzero byte written at clock edge W makes `comp_req` high for exactly one cycle after edges W+P, W+2P, and so on. Here P = (mantissa*16+15) * 2^exponent, and the largest value is 65408.
- R5: In power-down mode (`pwr_down` = 1), an expiry emits no pulse and sets a pending flag. A `recharge_stb` sampled at edge R while the flag is set gives one pulse after edge R and clears the flag. Several expiries before the strobe give a single pulse.
- R6: Moving from power-down to active mode with a request pending emits nothing by itself. The pending request is still released by the next recharge strobe, and expiries in active mode fire directly as in R4.
- R7: While `hf_lowpwr_ok` is low, the count is held at zero and no expiry occurs. If the qualifier is first sampled high at edge L, the first expiry pulse follows edge L-1+P.
- R8: Any configuration write restarts the count from zero using the new interval. An expiry due under the old count is dropped.
- R9: A recharge strobe with nothing pending produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data (bits 7:0 used) |
| cfg_rdata | output | 32 | Configuration readback |
| pwr_down | input | 1 | 1 = power-down mode, 0 = active mode |
| recharge_stb | input | 1 | One-cycle recharge event strobe |
| hf_lowpwr_ok | input | 1 | High when the crystal oscillator runs in low-power mode |
| comp_req | output | 1 | One-cycle amplitude-compensation request |

## Verification
The assertions rely on every input being synchronous to the 32 kHz clock and free of unknown values once reset is released. They also assume that `recharge_stb` and `cfg_we` are single-cycle events and that `pwr_down` changes only between clock edges. The stimulus meets these conditions in three ways:
- It changes every input only at the falling clock edge.
- It pulses the strobes for exactly one cycle.
- It places each recharge strobe on an edge that cannot coincide with an expiry, so every expected pulse time is exact.

// File: rtl/amct_pkg.sv
package amct_pkg;

   typedef enum logic {
      MODE_ACTIVE = 1'b0,
      MODE_PWRDN  = 1'b1
   } amct_mode_e;

   // bits needed to hold the longest coded interval
   function automatic int amct_period_bits(input int mant_w, input int exp_w, input int shift);
      return mant_w + shift + (1 << exp_w) - 1;
   endfunction

endpackage

// File: rtl/amct_cfg_reg.sv
module amct_cfg_reg #(
   parameter int DATA_W = 32,
   parameter int MANT_W = 5,
   parameter int EXP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [MANT_W-1:0] mant_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic              enabled_o
);
   localparam int FIELD_W = MANT_W + EXP_W;

   logic [FIELD_W-1:0] field_q;
   logic               unused_hi;

   assign unused_hi = ^cfg_wdata[DATA_W-1:FIELD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= '0;
      else if (cfg_we)
         field_q <= cfg_wdata[FIELD_W-1:0];
   end

   assign mant_o    = field_q[FIELD_W-1:EXP_W];
   assign exp_o     = field_q[EXP_W-1:0];
   assign enabled_o = |field_q;
   assign cfg_rdata = {{(DATA_W-FIELD_W){1'b0}}, field_q};

   // written byte reads back next cycle, upper bits zero
   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == DATA_W'($past(cfg_wdata[FIELD_W-1:0]))));

endmodule

// File: rtl/amct_period_dec.sv
module amct_period_dec #(
   parameter int MANT_W     = 5,
   parameter int EXP_W      = 3,
   parameter int SHIFT      = 4,
   parameter int CNT_W      = 23,
   parameter bit USE_BARREL = 1'b0
) (
   input  logic [MANT_W-1:0] mant_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic [CNT_W-1:0]  period_o
);
   localparam int BASE_W  = MANT_W + SHIFT;
   localparam int NUM_EXP = 1 << EXP_W;

   logic [BASE_W-1:0] base;
   assign base = {mant_i, {SHIFT{1'b1}}};

   if (USE_BARREL) begin : g_barrel
      assign period_o = CNT_W'(base) << exp_i;
   end else begin : g_table
      logic [CNT_W-1:0] cand [NUM_EXP];
      for (genvar e = 0; e < NUM_EXP; e++) begin : g_exp
         assign cand[e] = CNT_W'(base) << e;
      end
      assign period_o = cand[exp_i];
   end

endmodule

// File: rtl/amct_period_counter.sv
module amct_period_counter #(
   parameter int CNT_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end   = (cnt_q == (period_i - CNT_W'(1)));
   assign expire_o = run_i && !restart_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart_i || !run_i)
         cnt_q <= '0;
      else if (at_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // the count never passes the coded interval while running
   assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !restart_i) |-> (cnt_q < period_i));

   // a write starts the interval over
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   // qualifier low holds the count at zero
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/amct_req_ctrl.sv
module amct_req_ctrl
   import amct_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enabled_i,
   input  logic expire_i,
   input  logic pwr_down_i,
   input  logic recharge_i,
   output logic comp_req_o
);
   amct_mode_e mode;
   logic       pend_q;
   logic       pend_nx;
   logic       req_nx;
   logic       fire_now;
   logic       release_now;

   assign mode = amct_mode_e'(pwr_down_i);

   always_comb begin
      fire_now    = expire_i && (mode == MODE_ACTIVE);
      release_now = pend_q && recharge_i;
      pend_nx     = enabled_i && ((pend_q && !recharge_i) ||
                                  (expire_i && (mode == MODE_PWRDN)));
      req_nx      = enabled_i && (fire_now || release_now);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         comp_req_o <= 1'b0;
      end else begin
         pend_q     <= pend_nx;
         comp_req_o <= req_nx;
      end
   end

   assert_active_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled_i && expire_i && !pwr_down_i) |=> comp_req_o);

   assert_pd_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled_i && expire_i && pwr_down_i) |=> (pend_q && !comp_req_o));

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled_i && pend_q && recharge_i && !expire_i) |=> (comp_req_o && !pend_q));

   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled_i |=> (!comp_req_o && !pend_q));

   assert_no_spont_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!expire_i && !(pend_q && recharge_i)) |=> !comp_req_o);

   assert_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && recharge_i && !expire_i) |=> !comp_req_o);

endmodule

// File: rtl/amp_comp_timer.sv
module amp_comp_timer
   import amct_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MANT_W     = 5,
   parameter int EXP_W      = 3,
   parameter int SHIFT      = 4,
   parameter int CNT_W      = 23,
   parameter bit USE_BARREL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              pwr_down,
   input  logic              recharge_stb,
   input  logic              hf_lowpwr_ok,
   output logic              comp_req
);
   localparam int FIELD_W  = MANT_W + EXP_W;
   localparam int NEED_W   = amct_period_bits(MANT_W, EXP_W, SHIFT);

   if (CNT_W < NEED_W) begin : g_bad_cnt_w
      $error("amp_comp_timer: CNT_W too small for the longest interval");
   end
   if (DATA_W <= FIELD_W) begin : g_bad_data_w
      $error("amp_comp_timer: DATA_W must exceed the field width");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("amp_comp_timer: SHIFT must be at least 1");
   end

   logic [MANT_W-1:0] mant;
   logic [EXP_W-1:0]  expo;
   logic              enabled;
   logic [CNT_W-1:0]  period;
   logic              expire;
   logic              run;

   assign run = enabled && hf_lowpwr_ok;

   amct_cfg_reg #(
      .DATA_W (DATA_W),
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .mant_o    (mant),
      .exp_o     (expo),
      .enabled_o (enabled)
   );

   amct_period_dec #(
      .MANT_W     (MANT_W),
      .EXP_W      (EXP_W),
      .SHIFT      (SHIFT),
      .CNT_W      (CNT_W),
      .USE_BARREL (USE_BARREL)
   ) u_dec (
      .mant_i   (mant),
      .exp_i    (expo),
      .period_o (period)
   );

   amct_period_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .restart_i (cfg_we),
      .period_i  (period),
      .expire_o  (expire)
   );

   amct_req_ctrl u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .enabled_i  (enabled),
      .expire_i   (expire),
      .pwr_down_i (pwr_down),
      .recharge_i (recharge_stb),
      .comp_req_o (comp_req)
   );

   // a pulse needs a cause on the previous edge
   assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(comp_req) |-> $past(enabled));

endmodule

// File: tb/amp_comp_timer_test.sv
`timescale 1ns/1ps
module amp_comp_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        pwr_down = 1'b0;
   logic        recharge_stb = 1'b0;
   logic        hf_lowpwr_ok = 1'b0;
   logic        comp_req;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc = cyc + 1;

   amp_comp_timer uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .pwr_down     (pwr_down),
      .recharge_stb (recharge_stb),
      .hf_lowpwr_ok (hf_lowpwr_ok),
      .comp_req     (comp_req)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic expect_req(input int at, input string tag);
      exp_t e;
      e.at  = at;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: pops expected pulses and compares against observed ones
   always @(negedge clk) begin
      if (rst_n && !done) begin
         while (sb.size() > 0 && sb[0].at < cyc) begin
            chk(1'b0, {sb[0].tag, " missing pulse at cycle"}, -1, sb[0].at);
            void'(sb.pop_front());
         end
         if (comp_req) begin
            if (sb.size() > 0 && sb[0].at == cyc) begin
               chk(1'b1, sb[0].tag, cyc, cyc);
               void'(sb.pop_front());
            end else begin
               chk(1'b0, "unexpected pulse (R3/R5/R6/R7/R8/R9) cycle", cyc, -1);
            end
         end
      end
   end

   task automatic wr(input logic [31:0] d, output int edge_at);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = d;
      edge_at   = cyc + 1;
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic recharge(output int edge_at);
      @(negedge clk);
      recharge_stb = 1'b1;
      edge_at      = cyc + 1;
      @(negedge clk);
      recharge_stb = 1'b0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic drain(input string tag);
      chk(sb.size() == 0, {tag, " outstanding expected pulses"}, sb.size(), 0);
      sb.delete();
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int w, w2, r, z, l;
      repeat (3) @(negedge clk);
      chk(cfg_rdata == 32'h0, "R1 reset readback", cfg_rdata, 0);
      chk(comp_req == 1'b0, "R1 reset request", comp_req, 0);
      rst_n = 1'b1;
      hf_lowpwr_ok = 1'b1;
      repeat (2) @(negedge clk);

      // R2 + R4: M=1 E=2 -> 124, upper write bits ignored
      wr(32'hFFFF_FF0A, w);
      chk(cfg_rdata == 32'h0000_000A, "R2 readback with reserved bits", cfg_rdata, 32'h0A);
      expect_req(w + 124, "R4 M1E2 first");
      expect_req(w + 248, "R4 M1E2 second");
      wait_until(w + 250);
      wr(32'h0, z);
      drain("R4");

      // R4: M=0 E=1 -> 30
      wr(32'h01, w);
      expect_req(w + 30, "R4 M0E1 #1");
      expect_req(w + 60, "R4 M0E1 #2");
      expect_req(w + 90, "R4 M0E1 #3");
      wait_until(w + 95);
      wr(32'h0, z);
      drain("R4");

      // R4: M=3 E=0 -> 63
      wr(32'h18, w);
      chk(cfg_rdata == 32'h18, "R2 mantissa field readback", cfg_rdata, 32'h18);
      expect_req(w + 63, "R4 M3E0 #1");
      expect_req(w + 126, "R4 M3E0 #2");
      wait_until(w + 130);
      wr(32'h0, z);
      drain("R4");

      // R8: rewrite mid-count restarts the interval (M=2 -> 47)
      wr(32'h10, w);
      wait_until(w + 20);
      wr(32'h10, w2);
      expect_req(w2 + 47, "R8 restart after rewrite");
      wait_until(w2 + 50);
      wr(32'h0, z);
      drain("R8");

      // R5 + R9: deferral, collapse of three expiries, idle strobe
      pwr_down = 1'b1;
      wr(32'h01, w);
      wait_until(w + 100);
      @(negedge clk);
      recharge_stb = 1'b1;
      r = cyc + 1;
      expect_req(r, "R5 release on recharge");
      @(negedge clk);
      recharge_stb = 1'b0;
      @(negedge clk);
      recharge(r);
      wait_until(r + 3);
      wr(32'h0, z);
      pwr_down = 1'b0;
      drain("R5 R9");

      // R6: mode switch alone does not release
      pwr_down = 1'b1;
      wr(32'h01, w);
      wait_until(w + 40);
      pwr_down = 1'b0;
      expect_req(w + 60, "R6 active expiry after switch");
      wait_until(w + 65);
      @(negedge clk);
      recharge_stb = 1'b1;
      r = cyc + 1;
      expect_req(r, "R6 old pending released by recharge");
      @(negedge clk);
      recharge_stb = 1'b0;
      wait_until(r + 3);
      wr(32'h0, z);
      drain("R6");

      // R3: zero clears pending and silences the timer
      pwr_down = 1'b1;
      wr(32'h01, w);
      wait_until(w + 40);
      wr(32'hFFFF_FF00, z);
      chk(cfg_rdata == 32'h0, "R3 zero field readback", cfg_rdata, 0);
      wait_until(z + 3);
      recharge(r);
      pwr_down = 1'b0;
      wait_until(z + 120);
      drain("R3");

      // R7: qualifier gates counting
      hf_lowpwr_ok = 1'b0;
      wr(32'h01, w);
      wait_until(w + 100);
      hf_lowpwr_ok = 1'b1;
      l = cyc + 1;
      expect_req(l - 1 + 30, "R7 first expiry after qualifier rise");
      wait_until(l + 45);
      hf_lowpwr_ok = 1'b0;
      wait_until(l + 100);
      hf_lowpwr_ok = 1'b1;
      l = cyc + 1;
      expect_req(l - 1 + 30, "R7 count restarts from zero");
      wait_until(l + 35);
      wr(32'h0, z);
      drain("R7");

      // R4: largest interval M=31 E=7 -> 65408
      wr(32'hFF, w);
      expect_req(w + 65408, "R4 longest interval");
      wait_until(w + 65412);
      wr(32'h0, z);
      drain("R4 longest");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule